// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache that sits between a requester and a slower, word-wide memory. A byte address is split into three fields: a tag in the high bits, a set index in the middle, and a word-and-byte offset in the low bits. The set index picks one set, and each set holds two lines, one in each way. The two stored tags of that set are compared with the request tag in the same cycle. Each comparison only counts when that way's valid bit is set. The way that matches steers the output multiplexer, and the cache reports a hit when either way matches.

On a miss the block raises a stall and picks a victim way. An empty way is taken first. If both ways are full, the block takes the way named by a one-bit least-recently-used marker kept for each set. It then reads the whole line from memory, one word at a time, in ascending word order, and installs the tag and valid bit once the last word has arrived. The requester keeps its address steady while the stall is high. The cycle after the install, the same request hits and the word is returned. Every hit and every install moves the set's marker to the other way.

Top module: `twoway_rcache`

## Requirements
- R1: After reset every line is invalid: `stall`, `respValid` and `memReqValid` are low, and the first request to any address misses.
- R2: A request whose tag matches a valid way of its set returns that way's word on `respData` with `respValid` high in the same cycle, and `stall` stays low.
- R3: A request that matches neither way raises `stall` in its first cycle. The block then issues exactly WORDS memory reads at the line base address plus 4·i, for i = 0 up to WORDS−1 in ascending order. Each address is held until its `memRespValid`.
- R4: `respValid` for the stalled request rises in the cycle right after the clock edge that accepts the last refill word, and it carries the requested word.
- R5: When a set has an invalid way, the refill goes into an invalid way (way 0 before way 1), so the line already in the set is kept.
- R6: When both ways are valid, the victim is the way not used by the most recent hit or refill of that set. A hit to a line protects that line from the next replacement in its set.
- R7: A tag is never valid in both ways of one set, and a request that hits never starts a refill.
- R8: Sets are independent: a refill into one set changes neither the contents nor the replacement order of any other set.
- R9: Address bits [1:0] select a byte within the word and do not affect the lookup. Bits [3:2] select the word within a line, bits [6:4] the set, and bits [15:7] the tag (at default parameters).
- R10: `memReqValid` is low whenever no refill is in progress, including while hits are served and while no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqAddr | input | ADDR_W | Byte address of the request; held while `stall` is high |
| stall | output | 1 | Request cannot be served this cycle |
| respValid | output | 1 | `respData` holds the requested word |
| respData | output | DATA_W | Word read from the cache |
| memReqValid | output | 1 | Refill read pending at `memAddr` |
| memAddr | output | ADDR_W | Word-aligned address of the refill read |
| memRespValid | input | 1 | Memory returns the word for `memAddr` |
| memRespData | input | DATA_W | Refill word |

## Verification
The assertions assume that the requester holds `reqAddr` steady for as long as `stall` is high, and that `memRespValid` is only ever driven high while `memReqValid` is asserted. The bench's requester changes its address only after it has seen `respValid`. The bench's memory model waits for `memReqValid`, waits a fixed latency, and returns one word, so both assumptions hold for every stimulus. The memory word is a function of its address, which lets each returned word show which line and which word were read.

// File: rtl/twoway_rcache_pkg.sv
package twoway_rcache_pkg;

  typedef enum logic {
    ST_LOOK = 1'b0,
    ST_FILL = 1'b1
  } ctrlState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic latchMiss;    // capture miss address and victim way
    logic wordWe;       // write refill word into victim way
    logic installLine;  // set tag/valid of victim, update LRU
    logic lruTouch;     // hit: move LRU away from hit way
  } cacheStrobe_t;

endpackage

// File: rtl/twoway_rcache_way.sv
module twoway_rcache_way #(
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 9,
  localparam int SET_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(WORDS),
  localparam int LINE_W = SET_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SET_W-1:0]  lookSet,
  input  logic [TAG_W-1:0]  lookTag,
  input  logic [WORD_W-1:0] lookWord,
  input  logic [SET_W-1:0]  fillSet,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [WORD_W-1:0] fillWord,
  input  logic [DATA_W-1:0] fillData,
  input  logic              wordWe,
  input  logic              installLine,
  output logic              wayHit,
  output logic              wayValid,
  output logic [TAG_W-1:0]  wayTag,
  output logic [DATA_W-1:0] wayData
);

  logic [SETS-1:0]         validQ;
  logic [TAG_W-1:0]        tagQ  [SETS];
  logic [DATA_W-1:0]       dataQ [SETS*WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (installLine) begin
      validQ[fillSet] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (installLine) begin
      tagQ[fillSet] <= fillTag;
    end
    if (wordWe) begin
      dataQ[LINE_W'({fillSet, fillWord})] <= fillData;
    end
  end

  assign wayValid = validQ[lookSet];
  assign wayTag   = tagQ[lookSet];
  assign wayHit   = wayValid && (wayTag == lookTag);
  assign wayData  = dataQ[LINE_W'({lookSet, lookWord})];

endmodule

// File: rtl/twoway_rcache_dp.sv
module twoway_rcache_dp
  import twoway_rcache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  localparam int BYTE_W = $clog2(DATA_W/8),
  localparam int WORD_W = $clog2(WORDS),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - SET_W - WORD_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookAddr,
  input  cacheStrobe_t      strb,
  input  logic [WORD_W-1:0] fillIdx,
  input  logic [DATA_W-1:0] memRespData,
  output logic              hit,
  output logic [DATA_W-1:0] respData,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int WORD_LSB = BYTE_W;
  localparam int SET_LSB  = BYTE_W + WORD_W;
  localparam int TAG_LSB  = SET_LSB + SET_W;

  logic [TAG_W-1:0]  lookTag;
  logic [SET_W-1:0]  lookSet;
  logic [WORD_W-1:0] lookWord;

  assign lookTag  = lookAddr[ADDR_W-1:TAG_LSB];
  assign lookSet  = lookAddr[TAG_LSB-1:SET_LSB];
  assign lookWord = lookAddr[SET_LSB-1:WORD_LSB];

  logic [TAG_W-1:0] missTagQ;
  logic [SET_W-1:0] missSetQ;
  logic             victimQ;
  logic [SETS-1:0]  lruQ;   // way to replace next in each set

  logic [1:0]        wayHit;
  logic [1:0]        wayValid;
  logic [TAG_W-1:0]  wayTag  [2];
  logic [DATA_W-1:0] wayData [2];

  for (genvar w = 0; w < 2; w++) begin : g_way
    twoway_rcache_way #(
      .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)
    ) u_way (
      .clk        (clk),
      .rstN       (rstN),
      .lookSet    (lookSet),
      .lookTag    (lookTag),
      .lookWord   (lookWord),
      .fillSet    (missSetQ),
      .fillTag    (missTagQ),
      .fillWord   (fillIdx),
      .fillData   (memRespData),
      .wordWe     (strb.wordWe && (victimQ == 1'(w))),
      .installLine(strb.installLine && (victimQ == 1'(w))),
      .wayHit     (wayHit[w]),
      .wayValid   (wayValid[w]),
      .wayTag     (wayTag[w]),
      .wayData    (wayData[w])
    );
  end

  // Way-hit signals drive the output mux; overall hit is their OR
  assign hit      = |wayHit;
  assign respData = wayHit[1] ? wayData[1] : wayData[0];
  assign memAddr  = {missTagQ, missSetQ, fillIdx, {BYTE_W{1'b0}}};

  logic pickWay;
  always_comb begin
    if (!wayValid[0])      pickWay = 1'b0;
    else if (!wayValid[1]) pickWay = 1'b1;
    else                   pickWay = lruQ[lookSet];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missTagQ <= '0;
      missSetQ <= '0;
      victimQ  <= 1'b0;
    end else if (strb.latchMiss) begin
      missTagQ <= lookTag;
      missSetQ <= lookSet;
      victimQ  <= pickWay;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lruQ <= '0;
    end else if (strb.lruTouch) begin
      lruQ[lookSet] <= ~wayHit[1];
    end else if (strb.installLine) begin
      lruQ[missSetQ] <= ~victimQ;
    end
  end

  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rstN)
    !(wayValid[0] && wayValid[1] && (wayTag[0] == wayTag[1]))) else $error("dup tag"); // R7
  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wayHit)) else $error("two ways hit"); // R7
  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchMiss && !wayValid[0]) |=> (victimQ == 1'b0)) else $error("victim not invalid way"); // R5
  AST_LRU_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchMiss && (&wayValid)) |=> (victimQ == $past(lruQ[lookSet]))) else $error("victim not lru"); // R6
  AST_LRU_AFTER_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.lruTouch |=> (lruQ[$past(lookSet)] != $past(wayHit[1]))) else $error("lru not moved"); // R6

endmodule

// File: rtl/twoway_rcache_ctrl.sv
module twoway_rcache_ctrl
  import twoway_rcache_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              hit,
  input  logic              memRespValid,
  output cacheStrobe_t      strb,
  output logic [WORD_W-1:0] fillIdx,
  output logic              memReqValid,
  output logic              stall,
  output logic              respValid
);

  localparam logic [WORD_W-1:0] LAST_IDX = WORD_W'(WORDS - 1);

  ctrlState_t        stateQ, stateD;
  logic [WORD_W-1:0] idxQ, idxD;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    idxD   = idxQ;
    unique case (stateQ)
      ST_LOOK: begin
        if (reqValid && hit) begin
          strb.lruTouch = 1'b1;
        end else if (reqValid) begin
          strb.latchMiss = 1'b1;
          stateD         = ST_FILL;
          idxD           = '0;
        end
      end
      ST_FILL: begin
        if (memRespValid) begin
          strb.wordWe = 1'b1;
          if (idxQ == LAST_IDX) begin
            strb.installLine = 1'b1;
            stateD           = ST_LOOK;
          end else begin
            idxD = idxQ + 1'b1;
          end
        end
      end
      default: stateD = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_LOOK;
      idxQ   <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
    end
  end

  assign fillIdx     = idxQ;
  assign memReqValid = (stateQ == ST_FILL);
  assign respValid   = (stateQ == ST_LOOK) && reqValid && hit;
  assign stall       = (stateQ == ST_FILL) || (reqValid && !hit);

  AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRespValid && (idxQ != LAST_IDX)) |=> (idxQ == $past(idxQ) + 1'b1)) else $error("fill order"); // R3
  AST_FILL_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memRespValid && (idxQ == LAST_IDX)) |=> !memReqValid) else $error("fill overrun"); // R4

endmodule

// File: rtl/twoway_rcache.sv
module twoway_rcache
  import twoway_rcache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              stall,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData
);

  localparam int WORD_W = $clog2(WORDS);

  cacheStrobe_t      strb;
  logic [WORD_W-1:0] fillIdx;
  logic              hit;

  twoway_rcache_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .hit         (hit),
    .memRespValid(memRespValid),
    .strb        (strb),
    .fillIdx     (fillIdx),
    .memReqValid (memReqValid),
    .stall       (stall),
    .respValid   (respValid)
  );

  twoway_rcache_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lookAddr   (reqAddr),
    .strb       (strb),
    .fillIdx    (fillIdx),
    .memRespData(memRespData),
    .hit        (hit),
    .respData   (respData),
    .memAddr    (memAddr)
  );

  AST_HIT_QUIET_MEM: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !memReqValid) else $error("mem busy on hit"); // R10
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !respValid) |-> stall) else $error("miss without stall"); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRespValid) |=> (memReqValid && $stable(memAddr))) else $error("mem addr moved"); // R3

endmodule

// File: tb/twoway_rcache_test.sv
`timescale 1ns/1ps
module twoway_rcache_test;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        stall, respValid, memReqValid;
  logic [31:0] respData;
  logic [15:0] memAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int respCyc = 0;
  int logCount = 0;
  logic [15:0] memLog [16];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twoway_rcache uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .stall(stall), .respValid(respValid), .respData(respData),
    .memReqValid(memReqValid), .memAddr(memAddr),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  function automatic logic [31:0] memWord(input logic [15:0] a);
    return {a ^ 16'hC35A, a};
  endfunction

  // Default layout: tag [15:7], set [6:4], word [3:2], byte [1:0]
  function automatic logic [15:0] mk(input logic [8:0] t, input logic [2:0] s, input logic [1:0] w);
    return {t, s, w, 2'b00};
  endfunction

  // Memory model: fixed latency, one word per request
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        repeat (LAT) @(negedge clk);
        memRespData  = memWord(memAddr);
        memRespValid = 1'b1;
        if (logCount < 16) memLog[logCount] = memAddr;
        logCount = logCount + 1;
        respCyc  = cyc;
        @(negedge clk);
        memRespValid = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input bit expMiss, input string req);
    logic [31:0] got;
    bit missSeen;
    bit gotResp;
    int sampleCyc;
    got = '0;
    sampleCyc = 0;
    @(negedge clk);
    logCount = 0;
    reqValid = 1'b1;
    reqAddr  = a;
    #1;
    missSeen = stall;
    gotResp  = 1'b0;
    while (!gotResp) begin
      if (respValid) begin
        gotResp   = 1'b1;
        got       = respData;
        sampleCyc = cyc;
      end else begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    check(missSeen == expMiss, req, "miss flag", 32'(missSeen), 32'(expMiss));
    check(got == memWord({a[15:2], 2'b00}), req, "data", got, memWord({a[15:2], 2'b00}));
    if (expMiss) begin
      check(logCount == 4, "R3", "refill word count", 32'(logCount), 32'd4);
      for (int i = 0; i < 4; i++) begin
        check(memLog[i] == {a[15:4], 2'(i), 2'b00}, "R3", "refill address order",
              32'(memLog[i]), 32'({a[15:4], 2'(i), 2'b00}));
      end
      check(sampleCyc == respCyc + 1, "R4", "response cycle", 32'(sampleCyc), 32'(respCyc + 1));
    end else begin
      check(logCount == 0, "R10", "no memory read on hit", 32'(logCount), 32'd0);
    end
  endtask

  localparam logic [8:0] T1 = 9'h011;
  localparam logic [8:0] T2 = 9'h0A2;
  localparam logic [8:0] T3 = 9'h1F3;
  localparam int NVEC = 13;
  // {tag, set, word, expectMiss}
  localparam logic [14:0] VEC [NVEC] = '{
    {T1, 3'd0, 2'd0, 1'b1},  // cold miss
    {T1, 3'd0, 2'd3, 1'b0},  // hit, other word
    {T2, 3'd0, 2'd1, 1'b1},  // fills the empty way
    {T1, 3'd0, 2'd2, 1'b0},  // first line kept
    {T3, 3'd0, 2'd0, 1'b1},  // evicts T2
    {T1, 3'd0, 2'd1, 1'b0},  // protected by last hit
    {T2, 3'd0, 2'd0, 1'b1},  // evicts T3
    {T3, 3'd0, 2'd2, 1'b1},  // evicts T1
    {T2, 3'd0, 2'd3, 1'b0},  // hit, protects T2
    {T1, 3'd0, 2'd0, 1'b1},  // evicts T3
    {T1, 3'd5, 2'd2, 1'b1},  // other set cold
    {T2, 3'd0, 2'd1, 1'b0},  // set 0 untouched
    {T1, 3'd5, 2'd0, 1'b0}   // set 5 line present
  };
  string vecReq [NVEC] = '{"R1", "R2", "R5", "R5", "R6", "R6", "R6", "R6", "R6", "R6", "R8", "R8", "R8"};

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!stall, "R1", "stall after reset", 32'(stall), 32'd0);
    check(!respValid, "R1", "respValid after reset", 32'(respValid), 32'd0);
    check(!memReqValid, "R1", "memReqValid after reset", 32'(memReqValid), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      access(mk(VEC[v][14:6], VEC[v][5:3], VEC[v][2:1]), VEC[v][0], vecReq[v]);
    end

    // R9: byte bits do not change the lookup
    access(mk(T1, 3'd0, 2'd2) | 16'h0003, 1'b0, "R9");
    access(mk(T2, 3'd0, 2'd3) | 16'h0001, 1'b0, "R9");
    // R7: a present tag never starts a second fill
    access(mk(T2, 3'd0, 2'd0), 1'b0, "R7");
    access(mk(T1, 3'd0, 2'd3), 1'b0, "R7");

    // R10: idle cycles keep memory quiet
    begin
      bit sawReq;
      sawReq = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        #1;
        if (memReqValid || stall) sawReq = 1'b1;
      end
      check(!sawReq, "R10", "idle memory request", 32'(sawReq), 32'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule